// File: doc/BRIEF.md
# SPI Byte Shift Engine

This block runs a single serial transfer of 1 to 256 eight-bit words over a clock line, a data-out line and a data-in line. A one-cycle start pulse carries the word count (stored as count minus one), two direction flags and the bus timing: a 3-bit mode and an 8-bit clock divider. All of these are captured when the transfer is accepted. Each serial clock half-period lasts divider+1 cycles of the block clock, so the fastest bus rate is half the block clock.

When the write flag is set, the engine takes one transmit word per word from a valid/ready stream and shifts it out MSB first. When the read flag is set, every received word goes into a one-entry output holding stage with a valid/ready handshake. Both flags may be set together. With neither flag set, the bus is still clocked but no data moves. When the needed transmit word is missing, or the holding stage is still occupied, the engine waits between words with the serial clock at its idle level.

A controller state machine drives the whole transfer. Its states are IDLE, LOAD (wait for data and room, then fetch a word), LEAD (first half of a bit), TRAIL (second half of a bit) and DONE (one-cycle completion). The transitions are:
- IDLE to LOAD on start.
- LOAD to LEAD once the transmit data and receive room the flags call for are present.
- LEAD to TRAIL at the end of the half-period.
- TRAIL to LEAD when more bits of the word remain.
- TRAIL to LOAD after the last bit of a word when more words remain.
- TRAIL to DONE after the last bit of the last word.
- DONE to IDLE unconditionally.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, busy, done, tx_ready and rx_valid are 0, sclk is 0 (with mode 0) and sdo_oe is 1.
- R2: Within a word, consecutive sclk edges are exactly clk_div+1 block-clock cycles apart.
- R3: A transfer started with xfer_len = N produces exactly 16*(N+1) sclk edges (8 bits per word), with data shifted MSB first.
- R4: Mode bit 0 selects the sampling phase, bit 1 the clock polarity and bit 2 the 3-wire mode. sclk rests at the polarity bit between words and when idle. With phase 0, data is sampled on the first edge of each bit; with phase 1, on the second edge.
- R5: With flag bit 0 (write) set, one transmit word is consumed per word and appears on sdo MSB first. With it clear, no transmit word is consumed and sdo stays 0. tx_ready never rises without tx_valid.
- R6: With flag bit 1 (read) set, each received word is presented on rx_data with rx_valid, MSB first as sampled. With it clear, rx_valid never rises.
- R7: With both flags clear, the engine still clocks the full transfer but moves no data in either direction.
- R8: While a write transfer waits for a transmit word, sclk holds its idle level and no edges occur.
- R9: While rx_valid is held without rx_ready, rx_data stays stable and the next word does not begin.
- R10: In 3-wire mode with read set and write clear, sdo_oe is 0 for the transfer. Otherwise it is 1, and no transmit word is consumed while it is 0.
- R11: done is a one-cycle pulse in the cycle after the last bit completes, and busy falls in the cycle after done.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (reference) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| xfer_len | input | 8 | Word count minus one |
| xfer_flags | input | 2 | Bit 0 write, bit 1 read |
| mode | input | 3 | Bit 0 phase, bit 1 polarity, bit 2 3-wire |
| clk_div | input | 8 | Half-period is clk_div+1 cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_data | input | 8 | Transmit word |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 8 | Received word |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer accepts received word |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out drive enable (0 = released) |
| sdi | input | 1 | Serial data in |

## Verification
The bench runs a serial slave model that counts sclk edges. It drives and samples data on the edges set by the phase bit, for all four clock modes and several divider values, so that a design sampling on the wrong edge returns shifted or inverted words. The corner cases it targets are the following:
- A 256-word transfer, where a counter one bit too narrow would end early.
- Transfers with no data direction, where a design that still pops or pushes data would miscount.
- A starved transmit stream, where a design that keeps clocking would send garbage edges.
- A blocked receive stream, where a design that overwrites its holding stage would lose words.
- A start pulse arriving mid-transfer, where a design that restarts would change the edge count.
- The exact timing of done relative to the final edge, which a design with an extra pipeline stage would miss.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } eng_state_t;

    localparam int MODE_PHASE = 0;
    localparam int MODE_POL   = 1;
    localparam int MODE_3W    = 2;
    localparam int MODE_W     = 3;

    localparam int FLAG_WR = 0;
    localparam int FLAG_RD = 1;
    localparam int FLAG_W  = 2;
endpackage

// File: rtl/spi_eng_divider.sv
`timescale 1ns/1ps
module spi_eng_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !clear && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || tick)
            cnt <= div;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              capture,
    input  logic              shift,
    input  logic              sdi,
    output logic              msb,
    output logic [WORD_W-1:0] word_in
);
    logic [WORD_W-1:0] sreg;
    logic              samp;

    assign msb     = sreg[WORD_W-1];
    assign word_in = {sreg[WORD_W-2:0], samp};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            samp <= 1'b0;
        end else begin
            if (load)
                sreg <= load_val;
            else if (shift)
                sreg <= word_in;
            if (capture)
                samp <= sdi;
        end
    end
endmodule

// File: rtl/spi_eng_rxhold.sv
`timescale 1ns/1ps
module spi_eng_rxhold #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] word,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else if (push) begin
            rx_valid <= 1'b1;
            rx_data  <= word;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_eng_ctrl.sv
`timescale 1ns/1ps
module spi_eng_ctrl
    import spi_eng_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [FLAG_W-1:0] xfer_flags,
    input  logic [MODE_W-1:0] mode,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tick,
    input  logic              tx_valid,
    input  logic              rx_pending,
    output logic [DIV_W-1:0]  div_val,
    output logic              div_clear,
    output logic              load,
    output logic              capture,
    output logic              shift,
    output logic              push,
    output logic              tx_take,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              write_en,
    output logic              line_drive
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    eng_state_t       state, state_nxt;
    logic [LEN_W-1:0] words_left;
    logic [BIT_W-1:0] bit_left;
    logic             wr_q, rd_q, pha_q, pol_q, tw_q;
    logic [DIV_W-1:0] div_q;
    logic             go, last_bit, last_word;
    logic             pol_src, pha_src, sclk_nxt, sclk_q;

    assign go        = (!wr_q || tx_valid) && (!rd_q || !rx_pending);
    assign last_bit  = (bit_left == '0);
    assign last_word = (words_left == '0);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start) state_nxt = ST_LOAD;
            ST_LOAD:  if (go)    state_nxt = ST_LEAD;
            ST_LEAD:  if (tick)  state_nxt = ST_TRAIL;
            ST_TRAIL: if (tick)  state_nxt = !last_bit ? ST_LEAD :
                                             (last_word ? ST_DONE : ST_LOAD);
            ST_DONE:             state_nxt = ST_IDLE;
            default:             state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left <= '0;
            bit_left   <= '0;
            wr_q       <= 1'b0;
            rd_q       <= 1'b0;
            pha_q      <= 1'b0;
            pol_q      <= 1'b0;
            tw_q       <= 1'b0;
            div_q      <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                words_left <= xfer_len;
                wr_q       <= xfer_flags[FLAG_WR];
                rd_q       <= xfer_flags[FLAG_RD];
                pha_q      <= mode[MODE_PHASE];
                pol_q      <= mode[MODE_POL];
                tw_q       <= mode[MODE_3W];
                div_q      <= clk_div;
            end
            if (state == ST_LOAD && go)
                bit_left <= TOP_BIT;
            if (state == ST_TRAIL && tick) begin
                if (!last_bit)
                    bit_left <= bit_left - 1'b1;
                else if (!last_word)
                    words_left <= words_left - 1'b1;
            end
        end
    end

    // serial clock level follows the state being entered
    assign pol_src = (state == ST_IDLE) ? mode[MODE_POL]   : pol_q;
    assign pha_src = (state == ST_IDLE) ? mode[MODE_PHASE] : pha_q;

    always_comb begin
        unique case (state_nxt)
            ST_LEAD:  sclk_nxt = pol_src ^ pha_src;
            ST_TRAIL: sclk_nxt = ~(pol_src ^ pha_src);
            default:  sclk_nxt = pol_src;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk_q <= 1'b0;
        else
            sclk_q <= sclk_nxt;
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        div_clear  = !(state == ST_LEAD || state == ST_TRAIL);
        load       = (state == ST_LOAD) && go;
        tx_take    = (state == ST_LOAD) && go && wr_q;
        capture    = (state == ST_LEAD) && tick;
        shift      = (state == ST_TRAIL) && tick && !last_bit;
        push       = (state == ST_TRAIL) && tick && last_bit && rd_q;
        write_en   = wr_q;
        line_drive = !(busy && tw_q && rd_q && !wr_q);
        div_val    = div_q;
        sclk       = sclk_q;
    end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [1:0]        xfer_flags,
    input  logic [2:0]        mode,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);
    logic [DIV_W-1:0]  div_val;
    logic              div_clear, tick;
    logic              load, capture, shift, push, tx_take, write_en, line_drive;
    logic              msb;
    logic [WORD_W-1:0] word_in, load_val;

    spi_eng_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .xfer_flags(xfer_flags), .mode(mode), .clk_div(clk_div), .tick(tick),
        .tx_valid(tx_valid), .rx_pending(rx_valid), .div_val(div_val),
        .div_clear(div_clear), .load(load), .capture(capture), .shift(shift),
        .push(push), .tx_take(tx_take), .busy(busy), .done(done), .sclk(sclk),
        .write_en(write_en), .line_drive(line_drive)
    );

    spi_eng_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(div_clear), .div(div_val), .tick(tick)
    );

    assign load_val = write_en ? tx_data : '0;

    spi_eng_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .capture(capture), .shift(shift), .sdi(sdi), .msb(msb), .word_in(word_in)
    );

    spi_eng_rxhold #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .push(push), .word(word_in),
        .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    assign tx_ready = tx_take;
    assign sdo      = write_en & msb;
    assign sdo_oe   = line_drive;
endmodule

// File: rtl/spi_shift_engine_chk.sv
`timescale 1ns/1ps
module spi_shift_engine_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              sclk,
    input logic              pol_in,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [WORD_W-1:0] rx_data,
    input logic              sdo_oe
);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(rst_n) && $stable(pol_in)) |-> (sclk == pol_in));

    // R5
    tx_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R10
    released_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !tx_ready);
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk),
    .pol_in(mode[1]), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .sdo_oe(sdo_oe)
);

// File: tb/spi_shift_engine_test.sv
`timescale 1ns/1ps
module spi_shift_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] xfer_len = '0;
    logic [1:0] xfer_flags = '0;
    logic [2:0] mode = '0;
    logic [7:0] clk_div = '0;
    logic       busy, done;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready;
    logic       sclk, sdo, sdo_oe;
    logic       sdi_r = 1'b0;

    always #2.5 clk = ~clk;

    spi_shift_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .xfer_flags(xfer_flags), .mode(mode), .clk_div(clk_div), .busy(busy),
        .done(done), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .sclk(sclk),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi_r)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] txq[$];
    logic [7:0] exp_sdo[$];
    logic [7:0] exp_rx[$];
    bit  tx_en = 1'b1;
    bit  rx_rdy_en = 1'b1;
    bit  active = 1'b0;
    bit  cur_pha, cur_pol, exp_oe;
    int  cur_div, cur_seed;
    int  ec, mcnt, sp, tx_pulls, rx_count, done_cnt;
    logic [7:0] mbits;
    realtime t_last, t_done;

    assign rx_ready = rx_rdy_en;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] slv_byte(input int k);
        return 8'((k * 37 + cur_seed * 11 + 5) & 255);
    endfunction

    function automatic logic slv_bit(input int b);
        logic [7:0] v;
        v = slv_byte(b / 8);
        return v[7 - (b % 8)];
    endfunction

    // transmit stream feeder
    initial begin
        bit t;
        forever begin
            @(negedge clk);
            t = tx_valid && tx_ready;
            if (t) tx_pulls++;
            @(posedge clk);
            #1;
            if (t && txq.size() > 0) void'(txq.pop_front());
            tx_valid = tx_en && (txq.size() > 0);
            tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
        end
    end

    // receive scoreboard monitor and done monitor
    always @(negedge clk) begin
        if (rx_valid && rx_ready) begin
            rx_count++;
            if (exp_rx.size() == 0)
                chk(1'b0, "R6 unexpected rx word", rx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                chk(rx_data == e, "R6 rx word", rx_data, e);
            end
        end
        if (active && done) begin
            done_cnt++;
            if (done_cnt == 1) t_done = $realtime;
        end
    end

    // serial slave model
    always @(sclk) begin
        if (active) begin
            int pos;
            bit odd;
            ec++;
            pos = ((ec - 1) % 16) + 1;
            if (pos == 1)
                chk(sclk != cur_pol, "R4 first edge leaves idle level", sclk, !cur_pol);
            else
                chk(int'(($realtime - t_last) * 1000.0) == (cur_div + 1) * 5000,
                    "R2 half period", int'(($realtime - t_last) * 1000.0), (cur_div + 1) * 5000);
            t_last = $realtime;
            odd = (ec % 2) == 1;
            if (odd != cur_pha) begin
                mbits = {mbits[6:0], sdo};
                mcnt++;
                if (mcnt == 8) begin
                    logic [7:0] e;
                    mcnt = 0;
                    e = (exp_sdo.size() > 0) ? exp_sdo.pop_front() : 8'hxx;
                    chk(mbits == e, "R5 sdo word MSB first", mbits, e);
                    chk(sdo_oe == exp_oe, "R10 line drive", sdo_oe, exp_oe);
                end
            end else begin
                sdi_r = slv_bit(sp);
                sp++;
            end
        end
    end

    task automatic start_xfer(input logic [2:0] m, input logic [7:0] d,
                              input logic [1:0] f, input logic [7:0] l, input int seed);
        @(negedge clk);
        mode = m; clk_div = d; xfer_flags = f; xfer_len = l;
        cur_pha = m[0]; cur_pol = m[1]; cur_div = d; cur_seed = seed;
        exp_oe = !(m[2] && f == 2'b10);
        for (int k = 0; k <= int'(l); k++) begin
            logic [7:0] b;
            b = 8'((k * 13 + seed * 7 + 1) & 255);
            if (f[0]) begin
                txq.push_back(b);
                exp_sdo.push_back(b);
            end else
                exp_sdo.push_back(8'h00);
            if (f[1]) exp_rx.push_back(slv_byte(k));
        end
        ec = 0; mcnt = 0; sp = 0; mbits = '0;
        tx_pulls = 0; rx_count = 0; done_cnt = 0;
        if (!cur_pha) begin
            sdi_r = slv_bit(0);
            sp = 1;
        end
        @(negedge clk);
        active = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_xfer(input logic [1:0] f, input logic [7:0] l);
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        active = 1'b0;
        chk(ec == 16 * (int'(l) + 1), "R3 edge count", ec, 16 * (int'(l) + 1));
        chk(tx_pulls == (f[0] ? int'(l) + 1 : 0), "R5 tx words taken", tx_pulls, f[0] ? int'(l) + 1 : 0);
        chk(rx_count == (f[1] ? int'(l) + 1 : 0), "R6 rx words given", rx_count, f[1] ? int'(l) + 1 : 0);
        chk(exp_sdo.size() == 0, "R3 words on sdo", exp_sdo.size(), 0);
        chk(sclk == cur_pol, "R4 idle level after", sclk, cur_pol);
        chk(done_cnt == 1, "R11 done width", done_cnt, 1);
        chk(busy == 1'b0, "R11 busy cleared", busy, 0);
        if (!cur_pha)
            chk(int'((t_done - t_last) * 1000.0) == 2500, "R11 done timing",
                int'((t_done - t_last) * 1000.0), 2500);
        exp_rx.delete();
        txq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(tx_ready == 0 && rx_valid == 0, "R1 handshakes", {tx_ready, rx_valid}, 0);
        chk(sclk == 0 && sdo_oe == 1, "R1 line levels", {sclk, sdo_oe}, 1);

        // R3 R5 R6 full duplex, phase 0 polarity 0, fastest rate
        start_xfer(3'b000, 8'd0, 2'b11, 8'd2, 1);
        finish_xfer(2'b11, 8'd2);

        // R4 phase 1 polarity 1, divider 3
        start_xfer(3'b011, 8'd3, 2'b11, 8'd3, 2);
        finish_xfer(2'b11, 8'd3);

        // R5 write only, phase 1 polarity 0
        start_xfer(3'b001, 8'd1, 2'b01, 8'd1, 3);
        finish_xfer(2'b01, 8'd1);

        // R6 read only, phase 0 polarity 1
        start_xfer(3'b010, 8'd2, 2'b10, 8'd2, 4);
        finish_xfer(2'b10, 8'd2);

        // R7 no data direction
        start_xfer(3'b000, 8'd1, 2'b00, 8'd1, 5);
        finish_xfer(2'b00, 8'd1);

        // R10 3-wire read only releases the line, 3-wire write keeps it
        start_xfer(3'b100, 8'd0, 2'b10, 8'd1, 6);
        @(negedge clk);
        chk(sdo_oe == 1'b0, "R10 released", sdo_oe, 0);
        finish_xfer(2'b10, 8'd1);
        start_xfer(3'b101, 8'd0, 2'b01, 8'd0, 7);
        finish_xfer(2'b01, 8'd0);

        // R8 starved transmit stream
        tx_en = 1'b0;
        start_xfer(3'b010, 8'd0, 2'b01, 8'd1, 8);
        repeat (40) @(negedge clk);
        chk(ec == 0, "R8 no edges while starved", ec, 0);
        chk(sclk == 1'b1 && busy == 1'b1, "R8 idle level while starved", {sclk, busy}, 3);
        tx_en = 1'b1;
        finish_xfer(2'b01, 8'd1);

        // R9 blocked receive holding stage
        rx_rdy_en = 1'b0;
        start_xfer(3'b000, 8'd0, 2'b10, 8'd2, 9);
        repeat (200) @(negedge clk);
        chk(ec == 16, "R9 waits after first word", ec, 16);
        chk(rx_valid == 1'b1 && rx_data == slv_byte(0), "R9 word held", rx_data, slv_byte(0));
        rx_rdy_en = 1'b1;
        finish_xfer(2'b10, 8'd2);

        // R12 start while busy ignored
        start_xfer(3'b000, 8'd2, 2'b01, 8'd0, 10);
        repeat (10) @(negedge clk);
        xfer_len = 8'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_xfer(2'b01, 8'd0);
        chk(busy == 1'b0, "R12 no restart", busy, 0);

        // R3 longest transfer, 256 words
        start_xfer(3'b001, 8'd0, 2'b01, 8'd255, 11);
        finish_xfer(2'b01, 8'd255);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule